// File: doc/BRIEF.md
# Dual-Region Raster Timing Generator

This block turns a pixel clock into the horizontal and vertical timing of a low-resolution console display. Every scanline is exactly 128 pixel clocks. A 2 MHz pixel clock therefore gives a 15625 Hz line rate. Columns are decoded into horizontal sync, horizontal blanking and a colour-burst gate. The picture area runs straight into sync, so there is no front porch, and the back porch is long enough to hold a wide burst window.

Vertical timing is counted in framebuffer rows, not in scanlines. Each row is repeated over several scanlines, and a sub-row index says which repeat is being drawn. A one-bit region input chooses between two frame shapes:

- The 60 Hz shape uses 4 scanlines per row and rows 0 to 65, for 264 lines in all.
- The 50 Hz shape uses 5 scanlines per row and rows 1 to 64, for 320 lines in all.

Vertical sync covers the rows at the bottom of the count. Composite sync is formed by XOR of the two sync signals. The region input is sampled only on the last clock of a frame, so a frame never changes shape part of the way through.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_col` counts 0 to 127 by one per clock and then wraps to 0, so a scanline is 128 clocks.
- R2: `hsync` is 1 exactly when `pix_col` is in 112..121.
- R3: `hblank` is 1 when `pix_col` is in 112..127 or 0..7, and 0 in 8..111. Column 111 is unblanked and column 112 is both blanked and in sync, so there is no front porch.
- R4: `burst` is 1 exactly when `pix_col` is in 122..127.
- R5: With the 60 Hz shape active (region value 0), `sub_line` steps 0..3 once per scanline and `fb_row` counts 0..65. A frame is 264 lines.
- R6: With the 50 Hz shape active (region value 1), `sub_line` steps 0..4 once per scanline and `fb_row` counts 1..64. A frame is 320 lines.
- R7: With the 60 Hz shape active, `vsync` is 1 exactly while `fb_row` is 64 or 65, which is 8 scanlines.
- R8: With the 50 Hz shape active, `vsync` is 1 exactly while `fb_row` is 64, which is 5 scanlines.
- R9: `vblank` equals `vsync` on every clock.
- R10: `csync` equals `hsync` XOR `vsync` on every clock.
- R11: `region_sel` is sampled only on the clock where `pix_col` is 127 on the last scanline of the last row. Changes at any other time have no effect on the current frame.
- R12: While `rst_n` is 0, and on the first clock after reset, `pix_col`, `sub_line` and `fb_row` are 0 and the 60 Hz shape is active, whatever the value of `region_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_sel | input | 1 | Frame shape for the next frame: 0 is 60 Hz, 1 is 50 Hz |
| pix_col | output | 7 | Pixel column within the scanline |
| fb_row | output | 7 | Framebuffer row being displayed |
| sub_line | output | 3 | Scanline index within the current row |
| hsync | output | 1 | Horizontal sync, active high |
| hblank | output | 1 | Horizontal blanking, active high |
| burst | output | 1 | Colour-burst gate, active high |
| vsync | output | 1 | Vertical sync, active high |
| vblank | output | 1 | Vertical blanking, active high |
| csync | output | 1 | Composite sync (hsync XOR vsync) |

## Verification
The hardest case to reach from the ports is a region change. Its effect only shows tens of thousands of clocks later, on the one clock that closes a frame. To reach it, the stimulus sweeps three complete frames, cycle by cycle, with the region input held at different values across the frame boundaries. It also toggles the input several times in the middle of frames, where the change must be ignored. The reset itself is applied with the 50 Hz value on the input, so the 60 Hz default and the first handover to the 50 Hz shape are both exercised.

// File: rtl/raster_pkg.sv
package raster_pkg;
   typedef enum logic {
      REGION_60 = 1'b0,
      REGION_50 = 1'b1
   } region_e;

   typedef struct packed {
      logic hsync;
      logic hblank;
      logic burst;
   } hflags_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
   parameter int LINE_PIX = 128,
   parameter int COL_W    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [COL_W-1:0] col,
   output logic             line_end
);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_PIX - 1);

   assign line_end = (col == COL_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)        col <= '0;
      else if (line_end) col <= '0;
      else               col <= col + 1'b1;
   end
endmodule

// File: rtl/raster_hdecode.sv
module raster_hdecode
   import raster_pkg::*;
#(
   parameter int LINE_PIX    = 128,
   parameter int COL_W       = 7,
   parameter int HS_START    = 112,
   parameter int HS_END      = 121,
   parameter int HB_END      = 7,
   parameter int BURST_START = 122,
   parameter int BURST_END   = 127
) (
   input  logic [COL_W-1:0] col,
   output hflags_t          flags
);
   localparam logic [COL_W-1:0] HS_S = COL_W'(HS_START);
   localparam logic [COL_W-1:0] HS_E = COL_W'(HS_END);
   localparam logic [COL_W-1:0] HB_E = COL_W'(HB_END);
   localparam logic [COL_W-1:0] BU_S = COL_W'(BURST_START);
   localparam logic [COL_W-1:0] BU_E = COL_W'(BURST_END);

   assign flags.hsync = (col >= HS_S) && (col <= HS_E);

   // Blanking either wraps through the end of the line or sits inside it.
   generate
      if (HB_END < HS_START) begin : g_blank_wrap
         assign flags.hblank = (col >= HS_S) || (col <= HB_E);
      end else if (HB_END == LINE_PIX - 1) begin : g_blank_tail
         assign flags.hblank = (col >= HS_S);
      end else begin : g_blank_inner
         assign flags.hblank = (col >= HS_S) && (col <= HB_E);
      end

      if (BURST_END == LINE_PIX - 1) begin : g_burst_tail
         assign flags.burst = (col >= BU_S);
      end else begin : g_burst_inner
         assign flags.burst = (col >= BU_S) && (col <= BU_E);
      end
   endgenerate
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
   import raster_pkg::*;
#(
   parameter int ROW_W   = 7,
   parameter int SUB_W   = 3,
   parameter int A_LINES = 4,
   parameter int A_FIRST = 0,
   parameter int A_LAST  = 65,
   parameter int A_VS    = 64,
   parameter int B_LINES = 5,
   parameter int B_FIRST = 1,
   parameter int B_LAST  = 64,
   parameter int B_VS    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_end,
   input  logic             region_sel,
   output logic [ROW_W-1:0] row,
   output logic [SUB_W-1:0] sub,
   output region_e          region_q,
   output logic             vsync
);
   logic [SUB_W-1:0] sub_last;
   logic [ROW_W-1:0] row_last;
   logic [ROW_W-1:0] vs_first;
   logic [ROW_W-1:0] row_first_nxt;
   logic             row_done;
   logic             frame_done;

   always_comb begin
      if (region_q == REGION_50) begin
         sub_last = SUB_W'(B_LINES - 1);
         row_last = ROW_W'(B_LAST);
         vs_first = ROW_W'(B_VS);
      end else begin
         sub_last = SUB_W'(A_LINES - 1);
         row_last = ROW_W'(A_LAST);
         vs_first = ROW_W'(A_VS);
      end
      row_first_nxt = region_sel ? ROW_W'(B_FIRST) : ROW_W'(A_FIRST);
   end

   assign row_done   = line_end && (sub == sub_last);
   assign frame_done = row_done && (row == row_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         region_q <= REGION_60;
         row      <= ROW_W'(A_FIRST);
         sub      <= '0;
      end else if (frame_done) begin
         region_q <= region_e'(region_sel);
         row      <= row_first_nxt;
         sub      <= '0;
      end else if (row_done) begin
         row      <= row + 1'b1;
         sub      <= '0;
      end else if (line_end) begin
         sub      <= sub + 1'b1;
      end
   end

   assign vsync = (row >= vs_first) && (row <= row_last);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int LINE_PIX    = 128,
   parameter int HS_START    = 112,
   parameter int HS_END      = 121,
   parameter int HB_END      = 7,
   parameter int BURST_START = 122,
   parameter int BURST_END   = 127,
   parameter int A_LINES     = 4,
   parameter int A_FIRST     = 0,
   parameter int A_LAST      = 65,
   parameter int A_VS        = 64,
   parameter int B_LINES     = 5,
   parameter int B_FIRST     = 1,
   parameter int B_LAST      = 64,
   parameter int B_VS        = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       region_sel,
   output logic [6:0] pix_col,
   output logic [6:0] fb_row,
   output logic [2:0] sub_line,
   output logic       hsync,
   output logic       hblank,
   output logic       burst,
   output logic       vsync,
   output logic       vblank,
   output logic       csync
);
   localparam int COL_W     = $clog2(LINE_PIX);
   localparam int MAX_LINES = (A_LINES > B_LINES) ? A_LINES : B_LINES;
   localparam int MAX_ROW   = (A_LAST > B_LAST) ? A_LAST : B_LAST;
   localparam int ROW_W     = $clog2(MAX_ROW + 1);
   localparam int SUB_W     = $clog2(MAX_LINES);

   // Elaboration-time parameter checks
   generate
      if ((1 << COL_W) != LINE_PIX || COL_W != 7) begin : g_bad_line
         $error("LINE_PIX must be a power of two giving a 7-bit column");
      end
      if (HS_START > HS_END || HS_END >= LINE_PIX) begin : g_bad_hsync
         $error("hsync window must lie inside the line");
      end
      if (BURST_START > BURST_END || BURST_END >= LINE_PIX) begin : g_bad_burst
         $error("burst window must lie inside the line");
      end
      if (MAX_LINES < 2 || SUB_W > 3) begin : g_bad_sub
         $error("lines per row must be 2..8");
      end
      if (ROW_W > 7) begin : g_bad_row
         $error("row count must fit in 7 bits");
      end
      if (A_FIRST > A_VS || A_VS > A_LAST || B_FIRST > B_VS || B_VS > B_LAST) begin : g_bad_rows
         $error("row ranges must satisfy first <= vsync start <= last");
      end
   endgenerate

   logic [COL_W-1:0] col;
   logic             line_end;
   hflags_t          hf;
   logic [ROW_W-1:0] row;
   logic [SUB_W-1:0] sub;
   region_e          region_q;
   logic             vs;

   raster_hcount #(
      .LINE_PIX (LINE_PIX),
      .COL_W    (COL_W)
   ) u_hcount (
      .clk      (clk),
      .rst_n    (rst_n),
      .col      (col),
      .line_end (line_end)
   );

   raster_hdecode #(
      .LINE_PIX    (LINE_PIX),
      .COL_W       (COL_W),
      .HS_START    (HS_START),
      .HS_END      (HS_END),
      .HB_END      (HB_END),
      .BURST_START (BURST_START),
      .BURST_END   (BURST_END)
   ) u_hdecode (
      .col   (col),
      .flags (hf)
   );

   raster_vcount #(
      .ROW_W   (ROW_W),
      .SUB_W   (SUB_W),
      .A_LINES (A_LINES),
      .A_FIRST (A_FIRST),
      .A_LAST  (A_LAST),
      .A_VS    (A_VS),
      .B_LINES (B_LINES),
      .B_FIRST (B_FIRST),
      .B_LAST  (B_LAST),
      .B_VS    (B_VS)
   ) u_vcount (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_end   (line_end),
      .region_sel (region_sel),
      .row        (row),
      .sub        (sub),
      .region_q   (region_q),
      .vsync      (vs)
   );

   assign pix_col  = 7'(col);
   assign fb_row   = 7'(row);
   assign sub_line = 3'(sub);
   assign hsync    = hf.hsync;
   assign hblank   = hf.hblank;
   assign burst    = hf.burst;
   assign vsync    = vs;
   assign vblank   = vs;
   assign csync    = hf.hsync ^ vs;
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
   parameter int LINE_PIX = 128,
   parameter int HS_START = 112,
   parameter int HS_END   = 121,
   parameter int A_LINES  = 4,
   parameter int B_LINES  = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic [6:0] pix_col,
   input logic [6:0] fb_row,
   input logic [2:0] sub_line,
   input logic       hsync,
   input logic       hblank,
   input logic       burst,
   input logic       vsync,
   input logic       region_q
);
   localparam logic [6:0] COL_LAST = 7'(LINE_PIX - 1);
   localparam logic [6:0] HS_S     = 7'(HS_START);
   localparam logic [6:0] HS_AFTER = 7'(HS_END + 1);
   localparam logic [2:0] A_L      = 3'(A_LINES);
   localparam logic [2:0] B_L      = 3'(B_LINES);

   p_col_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_col == COL_LAST) |=> (pix_col == 7'd0));

   p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_col != COL_LAST) |=> (pix_col == 7'($past(pix_col) + 7'd1)));

   p_hsync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> (pix_col == HS_S));

   p_hsync_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hsync) |-> (pix_col == HS_AFTER));

   p_sync_blanked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> hblank);

   p_burst_in_porch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      burst |-> (hblank && !hsync));

   p_sub_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (region_q == 1'b0) |-> (sub_line < A_L));

   p_sub_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (region_q == 1'b1) |-> (sub_line < B_L));

   p_vcount_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_col != COL_LAST) |=> ($stable(fb_row) && $stable(sub_line)));

   p_vsync_on_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync) |-> ((pix_col == 7'd0) && (sub_line == 3'd0)));

   p_region_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_col != COL_LAST) |=> $stable(region_q));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(
   .LINE_PIX (LINE_PIX),
   .HS_START (HS_START),
   .HS_END   (HS_END),
   .A_LINES  (A_LINES),
   .B_LINES  (B_LINES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pix_col  (pix_col),
   .fb_row   (fb_row),
   .sub_line (sub_line),
   .hsync    (hsync),
   .hblank   (hblank),
   .burst    (burst),
   .vsync    (vsync),
   .region_q (region_q)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       region_sel = 1'b1;
   logic [6:0] pix_col;
   logic [6:0] fb_row;
   logic [2:0] sub_line;
   logic       hsync, hblank, burst, vsync, vblank, csync;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   int m_col  = 0;
   int m_line = 0;
   int m_mode = 0;
   int m_frame = 0;

   localparam int TOTAL = 264 * 128 + 320 * 128 + 264 * 128 + 256;

   always #5 clk = ~clk;

   raster_timing_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .region_sel (region_sel),
      .pix_col    (pix_col),
      .fb_row     (fb_row),
      .sub_line   (sub_line),
      .hsync      (hsync),
      .hblank     (hblank),
      .burst      (burst),
      .vsync      (vsync),
      .vblank     (vblank),
      .csync      (csync)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (frame %0d line %0d col %0d)",
                  tag, act, exp, m_frame, m_line, m_col);
      end
   endtask

   task automatic check_all();
      int lpr, first, e_row, e_sub, e_hs, e_hb, e_bu, e_vs;
      lpr   = (m_mode == 1) ? 5 : 4;
      first = (m_mode == 1) ? 1 : 0;
      e_row = first + m_line / lpr;
      e_sub = m_line % lpr;
      e_hs  = (m_col >= 112 && m_col <= 121) ? 1 : 0;
      e_hb  = (m_col >= 112 || m_col <= 7) ? 1 : 0;
      e_bu  = (m_col >= 122) ? 1 : 0;
      if (m_mode == 1) e_vs = (e_row == 64) ? 1 : 0;
      else             e_vs = (e_row >= 64) ? 1 : 0;
      chk("R1 pix_col", int'(pix_col), m_col);
      chk("R2 hsync", int'(hsync), e_hs);
      chk("R3 hblank", int'(hblank), e_hb);
      chk("R4 burst", int'(burst), e_bu);
      if (m_mode == 1) begin
         chk("R6 fb_row", int'(fb_row), e_row);
         chk("R6 sub_line", int'(sub_line), e_sub);
         chk("R8 vsync", int'(vsync), e_vs);
      end else begin
         chk("R5 fb_row", int'(fb_row), e_row);
         chk("R5 sub_line", int'(sub_line), e_sub);
         chk("R7 vsync", int'(vsync), e_vs);
      end
      chk("R9 vblank", int'(vblank), e_vs);
      chk("R10 csync", int'(csync), e_hs ^ e_vs);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      m_col++;
      if (m_col == 128) begin
         m_col = 0;
         m_line++;
         if (m_line == ((m_mode == 1) ? 320 : 264)) begin
            m_line = 0;
            m_mode = int'(region_sel);
            m_frame++;
         end
      end
   endtask

   initial begin
      // reset applied with the 50 Hz value on region_sel
      repeat (3) @(negedge clk);
      chk("R12 reset pix_col", int'(pix_col), 0);
      chk("R12 reset fb_row", int'(fb_row), 0);
      chk("R12 reset sub_line", int'(sub_line), 0);
      rst_n = 1'b1;
      chk("R12 first pix_col", int'(pix_col), 0);
      chk("R12 first fb_row", int'(fb_row), 0);
      chk("R12 first sub_line", int'(sub_line), 0);
      check_all();
      for (int n = 0; n < TOTAL; n++) begin
         step();
         check_all();
         if (m_col == 0 && m_line == 0) begin
            chk("R11 frame start fb_row", int'(fb_row), (m_mode == 1) ? 1 : 0);
            chk("R11 frame start sub_line", int'(sub_line), 0);
         end
         // mid-frame region toggles that must be ignored
         if (m_col == 3) begin
            if (m_frame == 0 && m_line == 50)  region_sel = 1'b0;
            if (m_frame == 0 && m_line == 51)  region_sel = 1'b1;
            if (m_frame == 1 && m_line == 100) region_sel = 1'b0;
            if (m_frame == 1 && m_line == 200) region_sel = 1'b1;
            if (m_frame == 1 && m_line == 300) region_sel = 1'b0;
            if (m_frame == 2 && m_line == 10)  region_sel = 1'b1;
            if (m_frame == 2 && m_line == 11)  region_sel = 1'b0;
         end
         if (m_col == 4 && ((m_frame == 0 && m_line == 50) ||
                            (m_frame == 1 && m_line == 100) ||
                            (m_frame == 2 && m_line == 10))) begin
            chk("R11 mid-frame change ignored", int'(sub_line),
                m_line % ((m_mode == 1) ? 5 : 4));
         end
      end
      chk("R11 frames completed", m_frame, 3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1_600_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule